// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Flags

This block is the byte-wide arithmetic and logic stage of a small RISC processor core. It takes two operands, the current carry and zero flags, and a four-bit operation code. Combinationally it returns the byte result, the candidate values of all six status flags, and a mask that says which flags this operation is allowed to change. The operations are: addition and subtraction with or without carry, the three bitwise logic operations, one's complement, negate, increment, decrement, three right shifts, a left rotate through carry, and a nibble swap.

A status register sits beside the combinational core. On every clock with `opValid` high, it takes the masked flags of the current operation. Unmasked flags keep their old value. Register file access, multiplication, branching and memory traffic live elsewhere in the core.

Top module: `alu_flags`

## Requirements
- R1: Flag vector bit positions: C=0, Z=1, N=2, V=3, S=4, H=5. Opcode 0 adds and opcode 1 adds plus `carryIn`. Both drive `result` with the low byte of the sum and update all six flags:
  - C is the carry out of bit 7.
  - H is the carry out of bit 3.
  - V is signed overflow.
  - N is bit 7 of the result.
  - Z is set when the result is zero.
- R2: Opcode 2 subtracts `opB` from `opA` and opcode 3 also subtracts `carryIn`. Both update all six flags:
  - C is the borrow out of bit 7.
  - H is the borrow out of bit 3.
  - V is signed overflow.
- R3: For opcode 3, Z is set only when the result is zero and `zeroIn` is 1. For opcode 1, Z depends on the result alone.
- R4: Opcodes 4 (AND), 5 (OR) and 6 (XOR) update Z, N, V and S, with V cleared. C and H are masked off.
- R5: Opcode 7 returns 0xFF minus `opA`. It sets C to 1, clears V, and updates Z, N and S. H is masked off.
- R6: Opcode 8 returns 0x00 minus `opA` and updates all six flags:
  - C is set when the result is non-zero.
  - V is set when the result is 0x80.
  - H is the borrow out of bit 3.
- R7: Opcode 9 adds 1 and opcode 10 subtracts 1. Both update Z, N, V and S, with V set on a 0x7F to 0x80 or 0x80 to 0x7F crossing. C and H are masked off.
- R8: The shift and rotate opcodes update C, Z, N, V and S, with V equal to N xor the new C. H is masked off. The opcodes are:
  - Opcode 11 shifts right with a 0 fill.
  - Opcode 12 rotates right with `carryIn` entering bit 7.
  - Opcode 13 shifts right keeping bit 7.
  - Opcode 14 rotates left with `carryIn` entering bit 0.
  - C takes the bit shifted out.
- R9: Opcode 15 exchanges the two nibbles of `opA`. Its flag mask is zero and the status register does not change.
- R10: Whenever N or V is written, S is written with N xor V. `statusQ` therefore always satisfies S = N xor V.
- R11: `statusQ` is 0 after reset. One clock after a cycle with `opValid` high, the masked bits of `statusQ` equal `flagVal` and the unmasked bits are unchanged. With `opValid` low, `statusQ` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Commit the current operation's flags into the status register |
| opCode | input | 4 | Operation select |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Incoming carry flag |
| zeroIn | input | 1 | Incoming zero flag |
| result | output | 8 | Combinational result |
| flagVal | output | 6 | Candidate flag values {H,S,V,N,Z,C} |
| flagMask | output | 6 | Per-flag write enables, same positions |
| statusQ | output | 6 | Registered status flags |

## Verification
Directed corner operands are applied and then several hundred random operations of every opcode. The directed operands are:
- 0x7F+1, 0x80-1 and 0x80 negated, which expose the signed-overflow rules.
- Nibble-edge values such as 0x0F+0x01 and 0x10-0x01, which separate half-carry from full carry.
- Zero results of subtract-with-carry with `zeroIn` both 0 and 1, which show the sticky zero.

For the random operations, `carryIn` and `zeroIn` are driven independently of the registered flags. This shows that the masked flags leave the status register untouched: for example, carry held across increment and H held across shifts.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FLAG_N_BITS = 6;
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBC = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_COM  = 4'd7,
    OP_NEG  = 4'd8,  OP_INC  = 4'd9,  OP_DEC  = 4'd10, OP_LSR  = 4'd11,
    OP_ROR  = 4'd12, OP_ASR  = 4'd13, OP_ROL  = 4'd14, OP_SWAP = 4'd15
  } op_e;

  typedef enum logic [1:0] { SEL_ADDER, SEL_LOGIC, SEL_SHIFT, SEL_SWAP } sel_e;
  typedef enum logic [1:0] { LG_AND, LG_OR, LG_XOR, LG_NOT } logic_e;
  typedef enum logic [1:0] { FILL_ZERO, FILL_CARRY, FILL_SIGN } fill_e;

  typedef struct packed {
    sel_e                   unitSel;
    logic                   subtract;
    logic                   useCarry;
    logic                   xZero;
    logic                   yOne;
    logic                   stickyZ;
    logic_e                 logicSel;
    logic                   forceC;
    fill_e                  fill;
    logic                   shiftLeft;
    logic [FLAG_N_BITS-1:0] mask;
  } ctrl_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opCode,
  output ctrl_t      ctrl
);
  localparam logic [FLAG_N_BITS-1:0] M_ALL   = 6'b111111;
  localparam logic [FLAG_N_BITS-1:0] M_ZNVS  = 6'b011110;
  localparam logic [FLAG_N_BITS-1:0] M_CZNVS = 6'b011111;

  always_comb begin
    ctrl = '{unitSel: SEL_ADDER, subtract: 1'b0, useCarry: 1'b0, xZero: 1'b0,
             yOne: 1'b0, stickyZ: 1'b0, logicSel: LG_AND, forceC: 1'b0,
             fill: FILL_ZERO, shiftLeft: 1'b0, mask: '0};
    case (op_e'(opCode))
      OP_ADD:  ctrl.mask = M_ALL;
      OP_ADDC: begin ctrl.useCarry = 1'b1; ctrl.mask = M_ALL; end
      OP_SUB:  begin ctrl.subtract = 1'b1; ctrl.mask = M_ALL; end
      OP_SUBC: begin ctrl.subtract = 1'b1; ctrl.useCarry = 1'b1; ctrl.stickyZ = 1'b1; ctrl.mask = M_ALL; end
      OP_AND:  begin ctrl.unitSel = SEL_LOGIC; ctrl.logicSel = LG_AND; ctrl.mask = M_ZNVS; end
      OP_OR:   begin ctrl.unitSel = SEL_LOGIC; ctrl.logicSel = LG_OR;  ctrl.mask = M_ZNVS; end
      OP_XOR:  begin ctrl.unitSel = SEL_LOGIC; ctrl.logicSel = LG_XOR; ctrl.mask = M_ZNVS; end
      OP_COM:  begin ctrl.unitSel = SEL_LOGIC; ctrl.logicSel = LG_NOT; ctrl.forceC = 1'b1; ctrl.mask = M_CZNVS; end
      OP_NEG:  begin ctrl.subtract = 1'b1; ctrl.xZero = 1'b1; ctrl.mask = M_ALL; end
      OP_INC:  begin ctrl.yOne = 1'b1; ctrl.mask = M_ZNVS; end
      OP_DEC:  begin ctrl.subtract = 1'b1; ctrl.yOne = 1'b1; ctrl.mask = M_ZNVS; end
      OP_LSR:  begin ctrl.unitSel = SEL_SHIFT; ctrl.fill = FILL_ZERO;  ctrl.mask = M_CZNVS; end
      OP_ROR:  begin ctrl.unitSel = SEL_SHIFT; ctrl.fill = FILL_CARRY; ctrl.mask = M_CZNVS; end
      OP_ASR:  begin ctrl.unitSel = SEL_SHIFT; ctrl.fill = FILL_SIGN;  ctrl.mask = M_CZNVS; end
      OP_ROL:  begin ctrl.unitSel = SEL_SHIFT; ctrl.fill = FILL_CARRY; ctrl.shiftLeft = 1'b1; ctrl.mask = M_CZNVS; end
      default: ctrl.unitSel = SEL_SWAP;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  ctrl_t                  ctrl,
  input  logic [WIDTH-1:0]       opA,
  input  logic [WIDTH-1:0]       opB,
  input  logic                   carryIn,
  input  logic                   zeroIn,
  output logic [WIDTH-1:0]       result,
  output logic [FLAG_N_BITS-1:0] flagVal
);
  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] xOp, yOp;
  logic             cinBit;
  logic [WIDTH:0]   wideSum;
  logic [HALF:0]    lowSum;
  logic [WIDTH-1:0] logicRes, shiftRes, swapRes;
  logic             fillBit;
  logic             cNew, hNew, vNew, nNew, zNew;

  assign xOp    = ctrl.xZero ? '0 : opA;
  assign yOp    = ctrl.yOne ? WIDTH'(1) : (ctrl.xZero ? opA : opB);
  assign cinBit = ctrl.useCarry & carryIn;

  always_comb begin
    if (ctrl.subtract) begin
      wideSum = {1'b0, xOp} - {1'b0, yOp} - (WIDTH+1)'(cinBit);
      lowSum  = {1'b0, xOp[HALF-1:0]} - {1'b0, yOp[HALF-1:0]} - (HALF+1)'(cinBit);
    end else begin
      wideSum = {1'b0, xOp} + {1'b0, yOp} + (WIDTH+1)'(cinBit);
      lowSum  = {1'b0, xOp[HALF-1:0]} + {1'b0, yOp[HALF-1:0]} + (HALF+1)'(cinBit);
    end
  end

  always_comb begin
    case (ctrl.logicSel)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = ~opA;
    endcase
  end

  always_comb begin
    case (ctrl.fill)
      FILL_CARRY: fillBit = carryIn;
      FILL_SIGN:  fillBit = opA[MSB];
      default:    fillBit = 1'b0;
    endcase
    shiftRes = ctrl.shiftLeft ? {opA[MSB-1:0], fillBit} : {fillBit, opA[MSB:1]};
  end

  assign swapRes = {opA[HALF-1:0], opA[MSB:HALF]};

  always_comb begin
    result = wideSum[WIDTH-1:0];
    cNew   = wideSum[WIDTH];
    hNew   = lowSum[HALF];
    vNew   = ctrl.subtract ? ((xOp[MSB] != yOp[MSB]) && (wideSum[MSB] != xOp[MSB]))
                           : ((xOp[MSB] == yOp[MSB]) && (wideSum[MSB] != xOp[MSB]));
    case (ctrl.unitSel)
      SEL_LOGIC: begin
        result = logicRes;
        cNew   = ctrl.forceC | carryIn;
        hNew   = 1'b0;
        vNew   = 1'b0;
      end
      SEL_SHIFT: begin
        result = shiftRes;
        cNew   = ctrl.shiftLeft ? opA[MSB] : opA[0];
        hNew   = 1'b0;
        vNew   = shiftRes[MSB] ^ cNew;
      end
      SEL_SWAP: begin
        result = swapRes;
        cNew   = carryIn;
        hNew   = 1'b0;
        vNew   = 1'b0;
      end
      default: ;
    endcase
    nNew = result[MSB];
    zNew = (result == '0) && (!ctrl.stickyZ || zeroIn);
    flagVal = '0;
    flagVal[F_C] = cNew;
    flagVal[F_Z] = zNew;
    flagVal[F_N] = nNew;
    flagVal[F_V] = vNew;
    flagVal[F_S] = nNew ^ vNew;
    flagVal[F_H] = hNew;
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic [7:0] opA,
  input  logic [7:0] opB,
  input  logic       carryIn,
  input  logic       zeroIn,
  output logic [7:0] result,
  output logic [5:0] flagVal,
  output logic [5:0] flagMask,
  output logic [5:0] statusQ
);
  ctrl_t ctrl;

  alu_ctrl u_ctrl (.opCode(opCode), .ctrl(ctrl));

  alu_datapath #(.WIDTH(8)) u_dp (
    .ctrl(ctrl), .opA(opA), .opB(opB), .carryIn(carryIn), .zeroIn(zeroIn),
    .result(result), .flagVal(flagVal)
  );

  assign flagMask = ctrl.mask;

  always_ff @(posedge clk) begin
    if (!rstN)        statusQ <= '0;
    else if (opValid) statusQ <= (statusQ & ~flagMask) | (flagVal & flagMask);
  end

  assert_sign_invariant_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[F_S] == (statusQ[F_N] ^ statusQ[F_V]));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(statusQ));

  assert_unmasked_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> ((statusQ & ~$past(flagMask)) == ($past(statusQ) & ~$past(flagMask))));

  assert_swap_no_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_SWAP) |=> $stable(statusQ));

  assert_incdec_keep_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_INC || opCode == OP_DEC)) |=> (statusQ[F_C] == $past(statusQ[F_C])));

  assert_com_sets_carry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_COM) |=> statusQ[F_C]);

  assert_sticky_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_SUBC && !zeroIn) |=> !statusQ[F_Z]);
endmodule

// File: tb/alu_flags_test.sv
module alu_flags_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] opA = '0, opB = '0;
  logic       carryIn = 1'b0, zeroIn = 1'b0;
  logic [7:0] result;
  logic [5:0] flagVal, flagMask, statusQ;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0] expStat = '0;

  always #2 clk = ~clk;

  alu_flags uut (.*);

  function automatic string reqTag(int op);
    case (op)
      0, 1:    return "R1";
      2:       return "R2";
      3:       return "R3";
      4, 5, 6: return "R4";
      7:       return "R5";
      8:       return "R6";
      9, 10:   return "R7";
      15:      return "R9";
      default: return "R8";
    endcase
  endfunction

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // behavioural model: returns {mask, flags, result}
  function automatic logic [19:0] model(int op, int a, int b, int c, int z);
    int r, full, nib, sv;
    bit fc, fz, fn, fv, fh;
    logic [5:0] m;
    fc = 0; fh = 0; fv = 0; r = 0;
    case (op)
      0, 1: begin
        if (op == 0) c = 0;
        full = a + b + c; nib = (a % 16) + (b % 16) + c; sv = sgn(a) + sgn(b) + c;
        r = full % 256; fc = full > 255; fh = nib > 15; fv = (sv > 127) || (sv < -128);
        m = 6'b111111;
      end
      2, 3, 8, 10: begin
        if (op == 8) begin b = a; a = 0; end
        if (op == 10) b = 1;
        if (op != 3) c = 0;
        full = a - b - c; nib = (a % 16) - (b % 16) - c; sv = sgn(a) - sgn(b) - c;
        r = (full + 512) % 256; fc = full < 0; fh = nib < 0; fv = (sv > 127) || (sv < -128);
        m = (op == 10) ? 6'b011110 : 6'b111111;
      end
      9: begin
        r = (a + 1) % 256; sv = sgn(a) + 1; fv = sv > 127; m = 6'b011110;
      end
      4: begin r = a & b; m = 6'b011110; end
      5: begin r = a | b; m = 6'b011110; end
      6: begin r = a ^ b; m = 6'b011110; end
      7: begin r = 255 - a; fc = 1; m = 6'b011111; end
      11, 12, 13: begin
        r = a / 2;
        if (op == 12 && c == 1) r = r + 128;
        if (op == 13 && a >= 128) r = r + 128;
        fc = a % 2; m = 6'b011111;
      end
      14: begin r = (a * 2 + c) % 256; fc = a >= 128; m = 6'b011111; end
      default: begin r = (a % 16) * 16 + a / 16; m = 6'b000000; end
    endcase
    fn = r >= 128;
    if (op >= 11 && op <= 14) fv = fn ^ fc;
    fz = (r == 0);
    if (op == 3) fz = fz && (z == 1);
    model = {m, m[0] ? {fh, fn ^ fv, fv, fn, fz, fc} : {fh, fn ^ fv, fv, fn, fz, 1'b0}, 8'(r)};
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic doOp(int op, int a, int b, int c, int z, bit v);
    logic [19:0] e;
    string t;
    @(negedge clk);
    opCode = 4'(op); opA = 8'(a); opB = 8'(b); carryIn = c[0]; zeroIn = z[0]; opValid = v;
    #1;
    e = model(op, a, b, c, z);
    t = reqTag(op);
    check(t, "result", result, e[7:0]);
    check(t, "flagMask", flagMask, e[19:14]);
    check(t, "maskedFlags", flagVal & e[19:14], e[13:8] & e[19:14]);
    if (v) expStat = (expStat & ~e[19:14]) | (e[13:8] & e[19:14]);
    @(posedge clk); #1;
    check(v ? "R11" : "R11_idle", "statusQ", statusQ, expStat);
    check("R10", "statusS", statusQ[4], statusQ[2] ^ statusQ[3]);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R11", "resetState", statusQ, 0);
    @(negedge clk) rstN = 1'b1;
    // R1 corners
    doOp(0, 8'h7F, 8'h01, 0, 0, 1);
    doOp(0, 8'h0F, 8'h01, 1, 0, 1);
    doOp(1, 8'hFF, 8'h00, 1, 0, 1);
    doOp(0, 8'h80, 8'h80, 0, 0, 1);
    // R2 corners
    doOp(2, 8'h10, 8'h01, 0, 0, 1);
    doOp(2, 8'h00, 8'h01, 0, 0, 1);
    doOp(2, 8'h80, 8'h01, 0, 0, 1);
    // R3 sticky zero
    doOp(3, 8'h05, 8'h04, 1, 1, 1);
    doOp(3, 8'h05, 8'h04, 1, 0, 1);
    doOp(1, 8'hFF, 8'h00, 1, 0, 1);
    // R4, R5
    doOp(4, 8'hF0, 8'h0F, 1, 0, 1);
    doOp(6, 8'hAA, 8'h2A, 0, 0, 1);
    doOp(7, 8'h00, 8'h00, 0, 0, 1);
    doOp(7, 8'hFF, 8'h00, 0, 0, 1);
    // R6 negate
    doOp(8, 8'h80, 0, 0, 0, 1);
    doOp(8, 8'h00, 0, 1, 0, 1);
    doOp(8, 8'h01, 0, 0, 0, 1);
    // R7 inc/dec keeps C and H
    doOp(0, 8'hFF, 8'h01, 0, 0, 1);
    doOp(9, 8'h7F, 0, 0, 0, 1);
    doOp(10, 8'h80, 0, 0, 0, 1);
    doOp(10, 8'h00, 0, 0, 0, 1);
    // R8 shifts
    doOp(11, 8'h01, 0, 1, 0, 1);
    doOp(12, 8'h02, 0, 1, 0, 1);
    doOp(13, 8'h81, 0, 0, 0, 1);
    doOp(14, 8'h80, 0, 1, 0, 1);
    // R9 swap, R11 idle hold
    doOp(15, 8'h3C, 0, 1, 1, 1);
    doOp(2, 8'h00, 8'h01, 0, 0, 0);
    // random sweep
    for (int i = 0; i < 600; i++)
      doOp($urandom % 16, $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 2,
           ($urandom % 8) != 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule